// File: doc/BRIEF.md
# Element-Serial Packed SIMD Divider

This block divides one 64-bit word by another, with each word read as a packed vector of equal-width integer elements. The element width (8, 16, 32 or 64 bits) and the operation (signed or unsigned, quotient or remainder) are chosen for each word. A single iterative restoring divider is shared by all the elements. An issue controller feeds it one element pair at a time, lowest element first. A separate commit controller collects each result, cuts it to the element width and shifts it into the output word from the top.

Operands enter through a valid/ready port and results leave through a second valid/ready port. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the assembled result has been taken, meaning an edge with `out_valid` and `out_ready` both high. While `out_ready` is low, the result waits, and `out_data` and `out_mask` hold steady. A per-byte mask selects which elements are computed at all. Per-byte enables select which bytes of a computed element take the result. Every byte that is not written keeps the dividend's byte.

Top module: `sdiv_simd`

## Requirements
- R1: `in_ew` selects the element width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Element k occupies bits starting at k times the width, so element 0 holds the least significant bits.
- R2: `in_op[0]` set means signed and `in_op[1]` set means remainder, giving 0 unsigned quotient, 1 signed quotient, 2 unsigned remainder and 3 signed remainder. For signed operations, elements are sign-extended. For unsigned operations they are zero-extended. Each result is truncated to the element width. Quotients round toward zero, and a remainder takes the dividend's sign.
- R3: The divider works on only one element at a time. Each element it computes takes at least 64 cycles, and the whole word is done within 66 cycles per computed element plus one cycle per element plus 3 cycles.
- R4: When the divisor is zero, the quotient is all ones within the element and the remainder equals the dividend element.
- R5: When the most negative element value is divided by -1 (signed), the quotient equals the dividend element and the remainder is zero.
- R6: An element whose lowest byte has a `in_mask` bit of 0 is skipped. The divider never runs for it, its bytes in `out_data` equal the dividend's bytes, and the skip costs one cycle.
- R7: Within a computed element, a byte whose `in_byte_en` bit is 0 takes the dividend's byte. Bytes with the bit set take the result.
- R8: `out_valid` rises only after every element has been committed. While `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `in_ready` is low from the accepting edge until the edge on which the result is taken. It is high again in the following cycle.
- R10: `out_mask` equals the `in_mask` captured with the word.
- R11: After reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operand word is offered |
| in_ready | output | 1 | The block can accept a word |
| in_dividend | input | 64 | Packed dividend elements |
| in_divisor | input | 64 | Packed divisor elements |
| in_mask | input | 8 | Per-byte mask; the bit of an element's lowest byte enables that element |
| in_byte_en | input | 8 | Per-byte write enable for results |
| in_op | input | 2 | Operation: bit 0 signed, bit 1 remainder |
| in_ew | input | 2 | Element width code |
| out_valid | output | 1 | The assembled result is available |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 64 | Assembled result word |
| out_mask | output | 8 | Mask captured with the word |

## Verification
A word with A computed elements out of N is due between 64·A and 66·A+N+3 edges after the accepting edge. It takes 66 edges per computed element and one per skipped element. The bench counts edges from acceptance, sampling on falling edges, and checks that the first `out_valid` lands inside that window. On every cycle of the wait it checks that `in_ready` is low. Results are compared against a behavioural model that computes each element with plain integer arithmetic. The bench also holds `out_ready` low for several cycles and checks, cycle by cycle, that the output stays unchanged. It then expects `in_ready` one cycle after the result is taken.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int WORD_W = 64;
  localparam int NBYTES = WORD_W / 8;
  localparam int CNT_W  = $clog2(NBYTES) + 1;
  localparam int POS_W  = $clog2(NBYTES);

  typedef enum logic [1:0] {EW_8 = 2'd0, EW_16 = 2'd1, EW_32 = 2'd2, EW_64 = 2'd3} ew_e;

  // bring the low element bits of v to a full word, signed or unsigned
  function automatic logic [WORD_W-1:0] ext_elem(input logic [WORD_W-1:0] v,
                                                 input ew_e ew, input logic sgn);
    case (ew)
      EW_8:    return {{(WORD_W-8){sgn & v[7]}},   v[7:0]};
      EW_16:   return {{(WORD_W-16){sgn & v[15]}}, v[15:0]};
      EW_32:   return {{(WORD_W-32){sgn & v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  input  logic         rem_sel,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W);
  typedef enum logic [1:0] {D_IDLE, D_RUN, D_FIN} dst_e;

  dst_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, bmag_q;
  logic          nega_q, negb_q, sgn_q, rsel_q, bzero_q;

  logic          nega, negb, qbit;
  logic [W:0]    rem_sh, diff;
  logic [W-1:0]  rem_nxt, q_fix, r_fix;

  assign nega   = sgn & a[W-1];
  assign negb   = sgn & b[W-1];
  assign rem_sh = {rem_q, quo_q[W-1]};
  assign diff   = rem_sh - {1'b0, bmag_q};
  assign qbit   = rem_sh >= {1'b0, bmag_q};
  assign rem_nxt = qbit ? diff[W-1:0] : rem_sh[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= D_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      bmag_q  <= '0;
      nega_q  <= 1'b0;
      negb_q  <= 1'b0;
      sgn_q   <= 1'b0;
      rsel_q  <= 1'b0;
      bzero_q <= 1'b0;
    end else begin
      case (st_q)
        D_IDLE: if (start) begin
          quo_q   <= nega ? -a : a;
          bmag_q  <= negb ? -b : b;
          rem_q   <= '0;
          cnt_q   <= '0;
          nega_q  <= nega;
          negb_q  <= negb;
          sgn_q   <= sgn;
          rsel_q  <= rem_sel;
          bzero_q <= (b == '0);
          st_q    <= D_RUN;
        end
        D_RUN: begin
          rem_q <= rem_nxt;
          quo_q <= {quo_q[W-2:0], qbit};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(W-1)) st_q <= D_FIN;
        end
        default: st_q <= D_IDLE;
      endcase
    end
  end

  // sign correction; a zero divisor keeps the all-ones quotient
  assign q_fix = bzero_q ? '1 : ((sgn_q & (nega_q ^ negb_q)) ? -quo_q : quo_q);
  assign r_fix = (sgn_q & nega_q) ? -rem_q : rem_q;
  assign res   = rsel_q ? r_fix : q_fix;
  assign done  = (st_q == D_FIN);

  assert_single_elem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> st_q == D_IDLE);
  assert_done_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sdiv_issue.sv
module sdiv_issue
  import sdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  nelem_in,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [NBYTES-1:0] mask,
  input  ew_e               ew,
  input  logic              sgn,
  input  logic              div_done,
  output logic              div_start,
  output logic [WORD_W-1:0] div_a,
  output logic [WORD_W-1:0] div_b,
  output logic              skip
);
  typedef enum logic [1:0] {I_IDLE, I_SEND, I_WAIT} ist_e;

  ist_e             st_q;
  logic [CNT_W-1:0] cnt_q, nelem;
  logic [POS_W-1:0] idx, pos;
  logic [5:0]       sh;
  logic             active;

  assign nelem  = CNT_W'(NBYTES) >> ew;
  assign idx    = POS_W'(nelem - cnt_q);
  assign pos    = idx << ew;
  assign sh     = {pos, 3'b000};
  assign active = mask[pos];

  assign div_a     = ext_elem(opa >> sh, ew, sgn);
  assign div_b     = ext_elem(opb >> sh, ew, sgn);
  assign div_start = (st_q == I_SEND) && active;
  assign skip      = (st_q == I_SEND) && !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= I_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        I_IDLE: if (go) begin
          cnt_q <= nelem_in;
          st_q  <= I_SEND;
        end
        I_SEND: begin
          cnt_q <= cnt_q - 1'b1;
          if (active)                        st_q <= I_WAIT;
          else if (cnt_q == CNT_W'(1))       st_q <= I_IDLE;
        end
        default: if (div_done) st_q <= (cnt_q == '0) ? I_IDLE : I_SEND;
      endcase
    end
  end

  assert_no_skip_while_dividing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> !div_done);
endmodule

// File: rtl/sdiv_commit.sv
module sdiv_commit
  import sdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  nelem_in,
  input  logic [WORD_W-1:0] opa,
  input  logic [NBYTES-1:0] mask,
  input  logic [NBYTES-1:0] be,
  input  ew_e               ew,
  input  logic              evt_div,
  input  logic              evt_skip,
  input  logic [WORD_W-1:0] div_res,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              busy
);
  typedef enum logic [1:0] {C_IDLE, C_RUN, C_OUT} cst_e;

  cst_e              st_q;
  logic [CNT_W-1:0]  cnt_q, nelem;
  logic [POS_W-1:0]  idx, pos;
  logic              active, evt;
  logic [WORD_W-1:0] piece, res_q, res_nxt;

  assign nelem  = CNT_W'(NBYTES) >> ew;
  assign idx    = POS_W'(nelem - cnt_q);
  assign pos    = idx << ew;
  assign active = mask[pos];
  assign evt    = evt_div | evt_skip;

  // merge result bytes with dividend bytes of the current element
  always_comb begin
    for (int j = 0; j < NBYTES; j++) begin
      logic [POS_W-1:0] p;
      p = pos + POS_W'(j);
      piece[8*j +: 8] = (active && be[p]) ? div_res[8*j +: 8] : opa[{p, 3'b000} +: 8];
    end
  end

  // shift the element in from the top
  always_comb begin
    case (ew)
      EW_8:    res_nxt = {piece[7:0],  res_q[WORD_W-1:8]};
      EW_16:   res_nxt = {piece[15:0], res_q[WORD_W-1:16]};
      EW_32:   res_nxt = {piece[31:0], res_q[WORD_W-1:32]};
      default: res_nxt = piece;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      cnt_q <= '0;
      res_q <= '0;
    end else begin
      case (st_q)
        C_IDLE: if (go) begin
          cnt_q <= nelem_in;
          st_q  <= C_RUN;
        end
        C_RUN: if (evt) begin
          res_q <= res_nxt;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) st_q <= C_OUT;
        end
        default: if (out_ready) st_q <= C_IDLE;
      endcase
    end
  end

  assign out_valid = (st_q == C_OUT);
  assign out_data  = res_q;
  assign busy      = (st_q != C_IDLE);

  assert_evt_only_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (st_q == C_RUN) && (cnt_q != '0));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
endmodule

// File: rtl/sdiv_simd.sv
module sdiv_simd
  import sdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_dividend,
  input  logic [63:0] in_divisor,
  input  logic [7:0]  in_mask,
  input  logic [7:0]  in_byte_en,
  input  logic [1:0]  in_op,
  input  logic [1:0]  in_ew,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic [7:0]  out_mask
);
  logic [WORD_W-1:0] opa_q, opb_q, div_a, div_b, div_res;
  logic [NBYTES-1:0] mask_q, be_q;
  logic [1:0]        op_q;
  ew_e               ew_q;
  logic              go, cbusy, div_start, div_done, skip;
  logic [CNT_W-1:0]  nelem_in;

  assign go       = in_valid && in_ready;
  assign in_ready = !cbusy;
  assign nelem_in = CNT_W'(NBYTES) >> in_ew;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q  <= '0;
      opb_q  <= '0;
      mask_q <= '0;
      be_q   <= '0;
      op_q   <= '0;
      ew_q   <= EW_8;
    end else if (go) begin
      opa_q  <= in_dividend;
      opb_q  <= in_divisor;
      mask_q <= in_mask;
      be_q   <= in_byte_en;
      op_q   <= in_op;
      ew_q   <= ew_e'(in_ew);
    end
  end

  sdiv_issue u_issue (
    .clk, .rst_n, .go, .nelem_in,
    .opa(opa_q), .opb(opb_q), .mask(mask_q), .ew(ew_q), .sgn(op_q[0]),
    .div_done, .div_start, .div_a, .div_b, .skip
  );

  sdiv_core #(.W(WORD_W)) u_core (
    .clk, .rst_n, .start(div_start), .a(div_a), .b(div_b),
    .sgn(op_q[0]), .rem_sel(op_q[1]), .done(div_done), .res(div_res)
  );

  sdiv_commit u_commit (
    .clk, .rst_n, .go, .nelem_in,
    .opa(opa_q), .mask(mask_q), .be(be_q), .ew(ew_q),
    .evt_div(div_done), .evt_skip(skip), .div_res,
    .out_ready, .out_valid, .out_data, .busy(cbusy)
  );

  assign out_mask = mask_q;

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_idle_divider_at_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !div_start && !div_done);
  assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_mask));
endmodule

// File: tb/tb_sdiv_simd.sv
module tb_sdiv_simd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_dividend = '0, in_divisor = '0;
  logic [7:0]  in_mask = '0, in_byte_en = '0;
  logic [1:0]  in_op = '0, in_ew = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic [7:0]  out_mask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sdiv_simd dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model of one word (R1, R2, R4, R5, R6, R7)
  function automatic logic [63:0] ref_word(input logic [63:0] a, input logic [63:0] b,
                                           input logic [7:0] m, input logic [7:0] e,
                                           input logic [1:0] op, input logic [1:0] ew);
    logic [63:0] r;
    int eb, w, n;
    r  = a;
    eb = 1 << ew;
    w  = 8 * eb;
    n  = 8 / eb;
    for (int k = 0; k < n; k++) begin
      int pos;
      logic [63:0] xa, xb, q, rm, res;
      pos = k * eb;
      if (m[pos]) begin
        xa = a >> (8 * pos);
        xb = b >> (8 * pos);
        if (w < 64) begin
          xa = xa << (64 - w);
          xb = xb << (64 - w);
          if (op[0]) begin
            xa = $signed(xa) >>> (64 - w);
            xb = $signed(xb) >>> (64 - w);
          end else begin
            xa = xa >> (64 - w);
            xb = xb >> (64 - w);
          end
        end
        if (xb == 64'd0) begin
          q = '1; rm = xa;
        end else if (op[0]) begin
          if (xa == 64'h8000_0000_0000_0000 && xb == '1) begin
            q = xa; rm = '0;
          end else begin
            q  = $signed(xa) / $signed(xb);
            rm = $signed(xa) % $signed(xb);
          end
        end else begin
          q = xa / xb; rm = xa % xb;
        end
        res = op[1] ? rm : q;
        for (int j = 0; j < eb; j++)
          if (e[pos + j]) r[8*(pos+j) +: 8] = res[8*j +: 8];
      end
    end
    return r;
  endfunction

  task automatic run_word(input logic [63:0] a, input logic [63:0] b, input logic [7:0] m,
                          input logic [7:0] e, input logic [1:0] op, input logic [1:0] ew,
                          input int hold, input string req);
    logic [63:0] exp, saved;
    int n, act_cnt, cyc, lo, hi;
    bit ready_ok, hold_ok;
    exp = ref_word(a, b, m, e, op, ew);
    n = 8 >> ew;
    act_cnt = 0;
    for (int k = 0; k < n; k++) if (m[k << ew]) act_cnt++;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready before word", {63'd0, in_ready}, 64'd1);
    in_valid = 1'b1; in_dividend = a; in_divisor = b; in_mask = m;
    in_byte_en = e; in_op = op; in_ew = ew;
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 1;
    ready_ok = 1'b1;
    while (!out_valid && cyc < 2000) begin
      if (in_ready) ready_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(ready_ok, "R9 ready low while busy", 64'd0, 64'd0);
    lo = 64 * act_cnt;
    hi = 66 * act_cnt + n + 3;
    chk(out_valid && cyc >= lo && cyc <= hi, $sformatf("R3 latency window [%0d,%0d]", lo, hi),
        64'(cyc), 64'(hi));
    chk(out_data == exp, {req, " result"}, out_data, exp);
    chk(out_mask == m, "R10 mask out", {56'd0, out_mask}, {56'd0, m});
    chk(!in_ready, "R9 ready low at output", {63'd0, in_ready}, 64'd0);
    saved = out_data;
    hold_ok = 1'b1;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!out_valid || out_data != saved) hold_ok = 1'b0;
    end
    if (hold > 0) chk(hold_ok, "R8 hold under back-pressure", out_data, saved);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R9 ready returns after take",
        {62'd0, out_valid, in_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R11 reset state", {62'd0, in_ready, out_valid}, 64'd2);

    // R1 8-bit unsigned quotient, all elements
    run_word(64'hFF80_6432_1000_0907, 64'h0F03_0705_0A01_0302, 8'hFF, 8'hFF, 2'd0, 2'd0, 0, "R1");
    // R2 signed 8-bit quotient incl. R5 (80/FF) and R4 (0A/00)
    run_word(64'h80F6_7F81_0A05_9C03, 64'hFF03_FDFF_00FB_07FE, 8'hFF, 8'hFF, 2'd1, 2'd0, 0, "R2 R5 R4");
    // R4 signed 16-bit remainder with zero divisor, back-pressure R8
    run_word(64'h8000_FFF9_1234_7FFF, 64'hFFFF_0002_0000_FFF0, 8'hFF, 8'hFF, 2'd3, 2'd1, 5, "R4 R2");
    // R2 unsigned 32-bit remainder
    run_word(64'hFFFF_FFFF_8000_0001, 64'h0000_0010_0000_0000, 8'hFF, 8'hFF, 2'd2, 2'd2, 0, "R2 R4");
    // R5 64-bit overflow case
    run_word(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 8'hFF, 2'd1, 2'd3, 0, "R5");
    // R4 64-bit unsigned divide by zero
    run_word(64'h1234_5678_9ABC_DEF0, 64'h0, 8'hFF, 8'hFF, 2'd0, 2'd3, 0, "R4");
    // R2 64-bit signed remainder, negative dividend
    run_word(64'hFFFF_FFFF_FFFF_FF9C, 64'd7, 8'hFF, 8'hFF, 2'd3, 2'd3, 2, "R2");
    // R6 partial mask, 8-bit
    run_word(64'h6442_3318_F0C8_7711, 64'h0305_0702_0904_0B06, 8'b1010_0101, 8'hFF, 2'd0, 2'd0, 0, "R6");
    // R7 partial byte enables, 16-bit signed
    run_word(64'h9000_7FFF_ABCD_0100, 64'h0003_0010_FFFE_0007, 8'hFF, 8'b0110_1001, 2'd1, 2'd1, 0, "R7");
    // R6 everything masked: result is the dividend, fast completion
    run_word(64'hDEAD_BEEF_0123_4567, 64'h0101_0101_0101_0101, 8'h00, 8'hFF, 2'd0, 2'd0, 0, "R6 all masked");
    // R1 32-bit signed quotient, mask only upper element
    run_word(64'hFFFF_FF00_0000_0064, 64'h0000_0010_0000_0003, 8'hF0, 8'hFF, 2'd1, 2'd2, 1, "R1 R6");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule